// File: doc/BRIEF.md
# SPI Slave Hold-Mode Front-End

This block is the serial front end of a memory-style SPI slave that can pause a transfer without stopping the serial clock. It samples chip select, hold, SCK, SI and the write-protect pin into a fast system clock through two-flop synchronizers. It finds SCK edges in those samples and shifts bytes in and out in SPI mode 0, most significant bit first. When the host asserts hold, the block freezes its shift registers and bit counter. It also releases SO by dropping the output-enable.

Entry into and exit from the paused state take effect only while SCK is low. A change of the hold pin during the high phase waits for the next low phase. If chip select is released while the transfer is paused, the block reports an abort to the command logic and clears its write-enable latch. A countdown timer models a self-timed program or erase cycle and keeps running through any pause. The write-protect level is passed through in every state.

Top module: `spi_hold_frontend`

## Requirements
- R1: SI is captured on SCK rising edges, MSB first. After every 8th rising edge in a selection, `rx_valid` pulses for exactly one clock and `rx_byte` holds the byte.
- R2: While selected and not paused, `so_oe` is 1 and `so` shows `tx_data` MSB first. The first bit is present before the first rising edge, and the next bit follows each falling edge. `tx_data` is reloaded after the falling edge that ends each byte.
- R3: The paused state begins only while chip select is low, and only in an SCK low phase. A hold assertion made while SCK is high takes effect at the start of the next low phase.
- R4: The paused state ends only in an SCK low phase. A hold release made while SCK is high takes effect at the next low phase.
- R5: While paused, `so_oe` is 0, SCK and SI activity is ignored, and the bit counter and shift registers keep their values. The byte resumes where it stopped.
- R6: `wp_prot` equals the inverted write-protect pin at all times, including while paused.
- R7: Raising chip select while paused gives a one-cycle `abort` pulse and clears `wel` to 0. No partial byte is reported.
- R8: Raising chip select while not paused resets the bit counter and sets `so_oe` to 0. It leaves `wel` unchanged and raises no abort.
- R9: A `busy_start` pulse while idle makes `busy` high for exactly BUSY_CYCLES clocks, whether or not the transfer is paused.
- R10: A `wel_set` pulse sets `wel` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause request, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| tx_data | input | DATA_W | Next byte to transmit |
| wel_set | input | 1 | Sets the write-enable latch |
| busy_start | input | 1 | Starts the self-timed cycle |
| so | output | 1 | Serial data out, valid while so_oe is 1 |
| so_oe | output | 1 | Output enable for so |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| abort | output | 1 | Transfer cut off while paused |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Self-timed cycle in progress |
| wp_prot | output | 1 | Write protection active |

## Verification
Assertions check several rules on every cycle. The paused state may start or stop only after a low SCK sample, and start only while selected. Bytes are never reported or counted while paused. Abort and a set latch never coincide, the busy counter falls by one per clock, and the byte strobe lasts one cycle. The bench covers what only whole scenarios can show. It sweeps every byte value in both directions and checks that a byte split by a pause, entered or left during either SCK phase, reassembles intact. It also checks the busy duration under a pause and the latch behaviour after the two kinds of deselect.

// File: rtl/spi_hold_pkg.sv
// Shared definitions for the hold-capable SPI front end.
// Assumes the pin bundle is synchronized as one vector.
package spi_hold_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic cs_n;
        logic hold_n;
        logic sck;
        logic si;
        logic wp_n;
    } pin_s;

    // Idle level of each pin: deselected, not paused, clock low, unprotected
    localparam pin_s PIN_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0, si: 1'b0, wp_n: 1'b1};
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; reset loads RST_VAL into all stages.
module spi_sync #(
    parameter int unsigned W       = 5,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-registers the one before
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= RST_VAL;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
// Pause state machine and SCK edge detector.
// Assumes synchronized inputs. The paused state changes only after a low SCK
// sample, and edges are suppressed while paused.
module spi_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic hold_n_s,
    input  logic sck_s,
    output logic held,
    output logic sck_rise,
    output logic sck_fall,
    output logic abort
);
    logic sck_prev;
    logic cs_prev;

    // Pause state: follows the hold pin only during SCK low, cleared when deselected
    always_ff @(posedge clk) begin
        if (!rst_n)        held <= 1'b0;
        else if (cs_n_s)   held <= 1'b0;
        else if (!sck_s)   held <= ~hold_n_s;
    end

    // History of SCK and chip select for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_n_s;
        end
    end

    // Abort pulse when chip select rises while paused
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else        abort <= cs_n_s & ~cs_prev & held;
    end

    assign sck_rise = sck_s & ~sck_prev & ~cs_n_s & ~held;
    assign sck_fall = ~sck_s & sck_prev & ~cs_n_s & ~held;
endmodule

// File: rtl/spi_shifter.sv
// Mode-0 shift engine: captures on rise, advances SO on fall, MSB first.
// Assumes rise/fall are already gated by the pause state. Deselect resets the count.
module spi_shifter #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              fall,
    input  logic              si_s,
    input  logic [DATA_W-1:0] tx_data,
    output logic              so_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [CW-1:0]     bit_cnt
);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    // Receive path: shift on rise, publish the byte after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sh   <= {rx_sh[DATA_W-2:0], si_s};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    rx_byte  <= {rx_sh[DATA_W-2:0], si_s};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // Transmit path: preload while deselected, reload at byte end, else shift on fall
    always_ff @(posedge clk) begin
        if (!rst_n)                   tx_sh <= '0;
        else if (!sel)                tx_sh <= tx_data;
        else if (fall && bit_cnt == '0) tx_sh <= tx_data;
        else if (fall)                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end

    assign so_bit = tx_sh[DATA_W-1];
endmodule

// File: rtl/spi_busy_timer.sv
// Countdown standing in for a self-timed program or erase cycle.
// Assumes start is ignored while counting; the pause state has no input here.
module spi_busy_timer #(
    parameter int unsigned CYCLES = 40,
    localparam int unsigned BW    = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [BW-1:0] cnt
);
    // Load on start when idle, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (cnt != '0)         cnt <= cnt - 1'b1;
        else if (start)             cnt <= BW'(CYCLES);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/spi_hold_frontend.sv
// Top of the hold-capable SPI slave front end.
// Assumes clk is several times faster than SCK. Pins go through two-flop
// synchronizers; so is meaningful only while so_oe is 1.
module spi_hold_frontend
    import spi_hold_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic              sck,
    input  logic              si,
    input  logic              wp_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              wel_set,
    input  logic              busy_start,
    output logic              so,
    output logic              so_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              abort,
    output logic              wel,
    output logic              busy,
    output logic              wp_prot
);
    localparam int unsigned CW = $clog2(DATA_W);
    localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

    pin_s          pins_raw;
    pin_s          pins_s;
    logic          held;
    logic          sck_rise;
    logic          sck_fall;
    logic          so_bit;
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] busy_cnt;

    assign pins_raw = '{cs_n: cs_n, hold_n: hold_n, sck: sck, si: si, wp_n: wp_n};

    spi_sync #(.W($bits(pin_s)), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    spi_hold_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s.cs_n), .hold_n_s(pins_s.hold_n),
        .sck_s(pins_s.sck), .held(held), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .abort(abort)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel(~pins_s.cs_n), .rise(sck_rise), .fall(sck_fall),
        .si_s(pins_s.si), .tx_data(tx_data), .so_bit(so_bit), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .bit_cnt(bit_cnt)
    );

    spi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy), .cnt(busy_cnt)
    );

    // Write-enable latch: abort clears with priority over a set request
    always_ff @(posedge clk) begin
        if (!rst_n)                            wel <= 1'b0;
        else if (pins_s.cs_n && held)          wel <= 1'b0;
        else if (wel_set)                      wel <= 1'b1;
    end

    assign so_oe   = ~pins_s.cs_n & ~held;
    assign so      = so_oe & so_bit;
    assign wp_prot = ~pins_s.wp_n;
endmodule

// File: rtl/spi_hold_frontend_chk.sv
// Cycle-level property checker for spi_hold_frontend, attached by bind.
// Assumes access to the synchronized pins and internal counters of the top.
module spi_hold_frontend_chk #(
    parameter int unsigned CW = 3,
    parameter int unsigned BW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          held,
    input logic          cs_n_s,
    input logic          sck_s,
    input logic          rx_valid,
    input logic          abort,
    input logic          wel,
    input logic [CW-1:0] bit_cnt,
    input logic [BW-1:0] busy_cnt
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R1
    AST_HOLD_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> (!$past(sck_s) && !$past(cs_n_s))); // R3
    AST_HOLD_EXIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(held) && !$past(cs_n_s)) |-> !$past(sck_s)); // R4
    AST_NO_RX_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> !rx_valid); // R5
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_n_s) |=> $stable(bit_cnt)); // R5
    AST_ABORT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !wel); // R7
    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - 1'b1)); // R9
endmodule

bind spi_hold_frontend spi_hold_frontend_chk #(.CW(CW), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .held(held), .cs_n_s(pins_s.cs_n), .sck_s(pins_s.sck),
    .rx_valid(rx_valid), .abort(abort), .wel(wel), .bit_cnt(bit_cnt), .busy_cnt(busy_cnt)
);

// File: tb/spi_hold_frontend_tb.sv
module spi_hold_frontend_tb;
    localparam int BC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, hold_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic [7:0] tx_data = '0;
    logic wel_set = 1'b0, busy_start = 1'b0;
    logic so, so_oe, rx_valid, abort, wel, busy, wp_prot;
    logic [7:0] rx_byte;

    int n_chk = 0, n_bad = 0, rx_cnt = 0, ab_cnt = 0, cyc = 0;
    logic [7:0] rx_last = '0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_hold_frontend #(.DATA_W(8), .BUSY_CYCLES(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .sck(sck), .si(si),
        .wp_n(wp_n), .tx_data(tx_data), .wel_set(wel_set), .busy_start(busy_start),
        .so(so), .so_oe(so_oe), .rx_byte(rx_byte), .rx_valid(rx_valid), .abort(abort),
        .wel(wel), .busy(busy), .wp_prot(wp_prot)
    );

    // Strobe monitors sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
        if (abort) ab_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    // One SCK period; checks SO against exp_so before the rising edge when chk is set
    task automatic sbit(input logic b, input logic exp_so, input bit chk);
        si = b;
        half();
        if (chk) check(so_oe && so == exp_so, "R2 so bit", {so_oe, so}, {1'b1, exp_so});
        sck = 1'b1;
        half();
        sck = 1'b0;
        half();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000", cyc);
            summary();
        end
    end

    initial begin
        int prev, c;
        logic [7:0] v, t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        half();
        check(!so_oe && !wel && !busy && rx_cnt == 0, "reset", {so_oe, wel, busy}, 0);
        check(!wp_prot, "R6 reset", wp_prot, 0);

        // R1/R2: exhaustive sweep over all byte values in both directions
        for (int k = 0; k < 256; k++) begin
            v = 8'(k); t = v ^ 8'h5A;
            tx_data = t; cs_n = 1'b0; prev = rx_cnt;
            half();
            for (int i = 7; i >= 0; i--) sbit(v[i], t[i], 1);
            check(rx_cnt == prev + 1 && rx_last == v, "R1 rx byte", rx_last, v);
            cs_n = 1'b1;
            half();
        end

        // R3/R5/R6/R9/R4: pause entered in low phase mid-byte
        v = 8'hB6; t = 8'h3C; tx_data = t; cs_n = 1'b0; prev = rx_cnt;
        half();
        for (int i = 7; i >= 4; i--) sbit(v[i], t[i], 1);
        hold_n = 1'b0; half();
        check(!so_oe, "R3 hold entry low phase", so_oe, 0);
        for (int j = 0; j < 2; j++) begin
            si = ~si; sck = 1'b1; half(); sck = 1'b0; half();
        end
        check(rx_cnt == prev, "R5 sck ignored in hold", rx_cnt, prev);
        check(!so_oe, "R5 so_oe low in hold", so_oe, 0);
        wp_n = 1'b0; half();
        check(wp_prot, "R6 wp live in hold", wp_prot, 1);
        wp_n = 1'b1; half();
        check(!wp_prot, "R6 wp release in hold", wp_prot, 0);
        busy_start = 1'b1; @(negedge clk); busy_start = 1'b0;
        c = 0;
        while (busy && c < 1000) begin c++; @(negedge clk); end
        check(c == BC, "R9 busy length in hold", c, BC);
        hold_n = 1'b1; half();
        check(so_oe && so == t[3], "R4 resume so", {so_oe, so}, {1'b1, t[3]});
        for (int i = 3; i >= 0; i--) sbit(v[i], t[i], 1);
        check(rx_cnt == prev + 1 && rx_last == v, "R5 byte intact after hold", rx_last, v);
        cs_n = 1'b1; half();

        // R3/R4: requests made during SCK high are deferred
        v = 8'h71; t = 8'hE8; tx_data = t; cs_n = 1'b0; prev = rx_cnt;
        half();
        for (int i = 7; i >= 5; i--) sbit(v[i], t[i], 1);
        si = v[4]; half(); sck = 1'b1; half();
        hold_n = 1'b0; half();
        check(so_oe, "R3 entry deferred in high", so_oe, 1);
        sck = 1'b0; half();
        check(!so_oe, "R3 entry at next low", so_oe, 0);
        sck = 1'b1; half();
        hold_n = 1'b1; half();
        check(!so_oe, "R4 exit deferred in high", so_oe, 0);
        sck = 1'b0; half();
        check(so_oe && so == t[3], "R4 exit at next low", {so_oe, so}, {1'b1, t[3]});
        for (int i = 3; i >= 0; i--) sbit(v[i], t[i], 1);
        check(rx_cnt == prev + 1 && rx_last == v, "R4 byte intact after deferred hold", rx_last, v);
        cs_n = 1'b1; half();

        // R10/R7: abort by deselect while paused
        wel_set = 1'b1; @(negedge clk); wel_set = 1'b0; half();
        check(wel, "R10 wel set", wel, 1);
        tx_data = 8'h00; cs_n = 1'b0; prev = rx_cnt; c = ab_cnt;
        half();
        sbit(1'b1, 1'b0, 0); sbit(1'b1, 1'b0, 0);
        hold_n = 1'b0; half();
        cs_n = 1'b1; half();
        check(ab_cnt == c + 1, "R7 abort pulse", ab_cnt, c + 1);
        check(!wel, "R7 wel cleared", wel, 0);
        check(rx_cnt == prev && !so_oe, "R7 no partial byte", rx_cnt, prev);
        hold_n = 1'b1; half();

        // R8: plain deselect mid-byte keeps wel, then counter restarts
        wel_set = 1'b1; @(negedge clk); wel_set = 1'b0;
        cs_n = 1'b0; c = ab_cnt; half();
        for (int j = 0; j < 3; j++) sbit(1'b1, 1'b0, 0);
        cs_n = 1'b1; half();
        check(wel, "R8 wel kept", wel, 1);
        check(ab_cnt == c && !so_oe, "R8 no abort, oe off", ab_cnt, c);
        v = 8'h96; t = 8'h69; tx_data = t; cs_n = 1'b0; prev = rx_cnt;
        half();
        for (int i = 7; i >= 0; i--) sbit(v[i], t[i], 1);
        check(rx_cnt == prev + 1 && rx_last == v, "R8 counter restarted", rx_last, v);
        cs_n = 1'b1; half();

        summary();
    end
endmodule